// File: doc/BRIEF.md
# Synchronous Peripheral Cycle Adapter

This block lets a processor with a handshaked, asynchronous bus reach slow peripherals that run from a fixed enable clock. It derives a free-running enable strobe `eOut` from the system clock. Each strobe period lasts ten system clocks: six with the strobe low, then four with it high. The strobe comes from a counter with no reset. Its phase against the system clock is therefore arbitrary after power-up, and it never stops, even during reset or while the bus is busy.

When the processor starts an access with `addrStrobe` and the address decoder raises `perDecode`, the adapter waits for the next falling edge of the enable strobe. At that edge it raises `vmaOut`, which tells the peripheral that the address is valid and that the cycle is locked to the strobe. `vmaOut` is held for exactly one strobe period. At the following falling edge, `vmaOut` drops and the adapter gives the processor side a one-clock `ackOut` that ends the bus cycle. The transfer direction is captured when the access is accepted and held on `perRead`. An access without `perDecode` never touches `vmaOut` or `ackOut`. If the strobe is withdrawn while the adapter is still waiting for alignment, the pending cycle is dropped.

Top module: `sync_periph_adapter`

## Requirements
- R1: `eOut` has a period of 10 clocks, low for 6 and high for 4. This holds from every power-on value of the 4-bit phase counter (0 to 15) once the first strobe transition has passed.
- R2: `eOut` keeps toggling while `rstN` is low and whatever the bus inputs do.
- R3: While `rstN` is low (asynchronous, active low), `vmaOut`, `ackOut` and `perRead` are 0.
- R4: An access is accepted at a clock edge where `addrStrobe` and `perDecode` are both sampled 1. `vmaOut` rises at the first clock edge, at or after acceptance, at which `eOut` falls. `vmaOut` rises at no other time.
- R5: `vmaOut` stays 1 for exactly 10 clocks. It falls at the next falling edge of `eOut`, and `ackOut` is 1 for exactly that one clock.
- R6: An access with `addrStrobe` 1 and `perDecode` 0 leaves `vmaOut` and `ackOut` at 0.
- R7: If `addrStrobe` is sampled 0 after acceptance but before `vmaOut` has risen, the cycle is abandoned: `vmaOut` and `ackOut` stay 0.
- R8: Dropping `addrStrobe` while `vmaOut` is 1 does not shorten the cycle, and `ackOut` still follows.
- R9: `perRead` takes the value of `readNotWrite` (1 = read) at the acceptance edge and stays unchanged while `vmaOut` is 1.
- R10: After `ackOut`, no new cycle is accepted until `addrStrobe` has been sampled 0. An access held active for 40 clocks produces exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of the cycle logic (not of the strobe counter) |
| addrStrobe | input | 1 | Processor access in progress, active high |
| readNotWrite | input | 1 | Transfer direction, 1 = read |
| perDecode | input | 1 | Decoder flag: the access targets a strobe-timed peripheral |
| eOut | output | 1 | Free-running enable strobe, 6 clocks low then 4 high |
| vmaOut | output | 1 | Address valid and cycle locked to the strobe |
| ackOut | output | 1 | One-clock transfer-complete pulse to the processor side |
| perRead | output | 1 | Direction captured at acceptance |

## Verification
The hardest thing to reach from the ports is a check of alignment against every strobe phase. The counter has no reset, so a single instance always meets an access at the same offset into its strobe period. The bench therefore builds sixteen instances, one for each power-on counter value, and drives them all with the same access sequence. Each access then lands at every offset into the strobe period, including the edge where the strobe falls in the same clock that the access is accepted. Short strobe pulses of one, three and eight clocks give abandoned and completed cycles side by side. A reset in the middle of a cycle and a strobe held for forty clocks cover the remaining corners.

// File: rtl/spa_pkg.sv
package spa_pkg;

  typedef enum logic [1:0] {
    CycIdle,
    CycWait,
    CycActive,
    CycDone
  } cycState_t;

  typedef struct packed {
    logic capture;
    logic setVma;
    logic endCycle;
  } cycStrobe_t;

endpackage

// File: rtl/spa_datapath.sv
module spa_datapath
  import spa_pkg::*;
#(
  parameter int LowClocks    = 6,
  parameter int HighClocks   = 4,
  parameter int CntW         = 4,
  parameter int PowerOnPhase = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       readNotWrite,
  input  cycStrobe_t strobe,
  output logic       eOut,
  output logic       fallNext,
  output logic       vmaOut,
  output logic       ackOut,
  output logic       perRead
);

  localparam int Period = LowClocks + HighClocks;
  localparam logic [CntW-1:0] LastPhase = CntW'(Period - 1);
  localparam logic [CntW-1:0] FirstHigh = CntW'(LowClocks);
  localparam logic InitE = (PowerOnPhase >= LowClocks) && (PowerOnPhase < Period);

  // Free-running phase counter: no reset, arbitrary start, self-correcting
  logic [CntW-1:0] phaseCnt = CntW'(PowerOnPhase);
  logic [CntW-1:0] phaseNext;
  logic            eReg = InitE;

  always_comb begin
    if (phaseCnt >= LastPhase) phaseNext = '0;
    else                       phaseNext = phaseCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    phaseCnt <= phaseNext;
    eReg     <= (phaseNext >= FirstHigh);
  end

  assign eOut     = eReg;
  assign fallNext = (phaseCnt == LastPhase);

  // Cycle outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vmaOut  <= 1'b0;
      ackOut  <= 1'b0;
      perRead <= 1'b0;
    end else begin
      ackOut <= strobe.endCycle;
      if (strobe.capture) perRead <= readNotWrite;
      if (strobe.endCycle)    vmaOut <= 1'b0;
      else if (strobe.setVma) vmaOut <= 1'b1;
    end
  end

endmodule

// File: rtl/spa_control.sv
module spa_control
  import spa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrStrobe,
  input  logic       perDecode,
  input  logic       fallNext,
  output cycStrobe_t strobe
);

  cycState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      CycIdle: begin
        if (addrStrobe && perDecode) begin
          strobe.capture = 1'b1;
          if (fallNext) begin
            strobe.setVma = 1'b1;
            stateNext     = CycActive;
          end else begin
            stateNext = CycWait;
          end
        end
      end
      CycWait: begin
        if (!addrStrobe) begin
          stateNext = CycIdle;
        end else if (fallNext) begin
          strobe.setVma = 1'b1;
          stateNext     = CycActive;
        end
      end
      CycActive: begin
        if (fallNext) begin
          strobe.endCycle = 1'b1;
          stateNext       = CycDone;
        end
      end
      CycDone: begin
        if (!addrStrobe) stateNext = CycIdle;
      end
      default: stateNext = CycIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CycIdle;
    else       state <= stateNext;
  end

endmodule

// File: rtl/sync_periph_adapter.sv
module sync_periph_adapter
  import spa_pkg::*;
#(
  parameter int LowClocks    = 6,
  parameter int HighClocks   = 4,
  parameter int PowerOnPhase = 0
) (
  input  logic clk,
  input  logic rstN,
  input  logic addrStrobe,
  input  logic readNotWrite,
  input  logic perDecode,
  output logic eOut,
  output logic vmaOut,
  output logic ackOut,
  output logic perRead
);

  localparam int Period = LowClocks + HighClocks;
  localparam int CntW   = (Period > 1) ? $clog2(Period) : 1;

  cycStrobe_t strobe;
  logic       fallNext;

  spa_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .addrStrobe(addrStrobe),
    .perDecode (perDecode),
    .fallNext  (fallNext),
    .strobe    (strobe)
  );

  spa_datapath #(
    .LowClocks   (LowClocks),
    .HighClocks  (HighClocks),
    .CntW        (CntW),
    .PowerOnPhase(PowerOnPhase)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .readNotWrite(readNotWrite),
    .strobe      (strobe),
    .eOut        (eOut),
    .fallNext    (fallNext),
    .vmaOut      (vmaOut),
    .ackOut      (ackOut),
    .perRead     (perRead)
  );

endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
  parameter int LowClocks  = 6,
  parameter int HighClocks = 4
) (
  input logic clk,
  input logic rstN,
  input logic addrStrobe,
  input logic eOut,
  input logic vmaOut,
  input logic ackOut,
  input logic perRead
);

  logic [7:0] highRun  = '0;
  logic [7:0] lowRun   = '0;
  logic       ePrev    = 1'b1;
  logic       seenRise = 1'b0;
  logic       seenFall = 1'b0;

  always_ff @(posedge clk) begin
    ePrev    <= eOut;
    seenRise <= seenRise | (eOut & ~ePrev);
    seenFall <= seenFall | (~eOut & ePrev & seenRise);
    if (eOut) begin
      lowRun  <= '0;
      if (highRun != 8'hFF) highRun <= highRun + 8'd1;
    end else begin
      highRun <= '0;
      if (lowRun != 8'hFF) lowRun <= lowRun + 8'd1;
    end
  end

  // R1
  e_high_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(eOut) && seenRise) |-> (highRun == 8'(HighClocks)));

  // R1
  e_low_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(eOut) && seenFall) |-> (lowRun == 8'(LowClocks)));

  // R4
  vma_on_e_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vmaOut) |-> $fell(eOut));

  // R7
  vma_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vmaOut) |-> $past(addrStrobe));

  // R5
  ack_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> ($fell(vmaOut) && $fell(eOut)));

  // R5
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut);

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vmaOut && $past(vmaOut)) |-> $stable(perRead));

endmodule

bind sync_periph_adapter spa_checker #(
  .LowClocks (LowClocks),
  .HighClocks(HighClocks)
) u_spa_checker (
  .clk       (clk),
  .rstN      (rstN),
  .addrStrobe(addrStrobe),
  .eOut      (eOut),
  .vmaOut    (vmaOut),
  .ackOut    (ackOut),
  .perRead   (perRead)
);

// File: tb/sync_periph_adapter_test.sv
`timescale 1ns/1ps
module sync_periph_adapter_test;

  localparam int ClkPeriod = 10;
  localparam int NumPhases = 16;
  localparam int LowLen    = 6;
  localparam int HighLen   = 4;
  localparam int VmaLen    = 10;

  typedef struct packed {
    logic [4:0] gap;
    logic       vpa;
    logic       rw;
    logic [4:0] hold;
    logic [1:0] expAll;  // 0 none ack, 1 all ack, 2 mixed
  } vec_t;

  localparam int NumVecs = 9;
  localparam vec_t Vecs [NumVecs] = '{
    '{5'd3, 1'b1, 1'b1, 5'd25, 2'd1},
    '{5'd1, 1'b1, 1'b0, 5'd25, 2'd1},
    '{5'd7, 1'b0, 1'b1, 5'd25, 2'd0},
    '{5'd2, 1'b1, 1'b1, 5'd3,  2'd2},
    '{5'd5, 1'b1, 1'b0, 5'd1,  2'd2},
    '{5'd4, 1'b1, 1'b1, 5'd12, 2'd1},
    '{5'd9, 1'b1, 1'b0, 5'd25, 2'd1},
    '{5'd6, 1'b0, 1'b0, 5'd4,  2'd0},
    '{5'd2, 1'b1, 1'b1, 5'd8,  2'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrStrobe = 1'b0;
  logic readNotWrite = 1'b0;
  logic perDecode = 1'b0;
  logic clrAcks = 1'b0;

  int checks = 0;
  int errors = 0;
  int ackCnt [NumPhases];

  logic [NumPhases-1:0] vmaAll, ackAll, eAll;

  always #(ClkPeriod/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  for (genvar g = 0; g < NumPhases; g++) begin : gen
    logic eW, vW, aW, pW;

    sync_periph_adapter #(.PowerOnPhase(g)) uut (
      .clk         (clk),
      .rstN        (rstN),
      .addrStrobe  (addrStrobe),
      .readNotWrite(readNotWrite),
      .perDecode   (perDecode),
      .eOut        (eW),
      .vmaOut      (vW),
      .ackOut      (aW),
      .perRead     (pW)
    );

    assign vmaAll[g] = vW;
    assign ackAll[g] = aW;
    assign eAll[g]   = eW;

    int   st = 0;
    int   eRun = 0;
    int   vRun = 0;
    logic primed = 1'b0;
    logic seen = 1'b0;
    logic prevE = 1'b0;
    logic expV = 1'b0, expA = 1'b0, expP = 1'b0;
    logic asP = 1'b0, vpaP = 1'b0, rwP = 1'b0, rstP = 1'b0;
    logic fell;
    string tag;

    always @(negedge clk) begin
      if (clrAcks) ackCnt[g] = 0;
      if (primed) begin
        // R1 R2: strobe run lengths, also across reset and bus activity
        if (eW == prevE) eRun++;
        else begin
          if (seen) chk(eRun == (prevE ? HighLen : LowLen), "R1 R2 strobe run length",
                        eRun, prevE ? HighLen : LowLen);
          seen = 1'b1;
          eRun = 1;
        end
        fell = prevE && !eW;
        expA = 1'b0;
        tag  = "R4";
        if (!rstN || !rstP) begin
          st = 0; expV = 1'b0; expP = 1'b0; tag = "R3";
        end else begin
          case (st)
            0: begin
              if (asP && !vpaP) tag = "R6";
              if (asP && vpaP) begin
                expP = rwP;
                if (fell) begin expV = 1'b1; st = 2; end
                else st = 1;
              end
            end
            1: begin
              tag = "R7";
              if (!asP) st = 0;
              else if (fell) begin expV = 1'b1; st = 2; tag = "R4"; end
            end
            2: begin
              tag = "R8";
              if (fell) begin expV = 1'b0; expA = 1'b1; st = 3; tag = "R5"; end
            end
            default: begin
              tag = "R10";
              if (!asP) st = 0;
            end
          endcase
        end
        chk(vW == expV, {tag, " vmaOut"}, int'(vW), int'(expV));
        chk(aW == expA, {tag, " ackOut"}, int'(aW), int'(expA));
        chk(pW == expP, (tag == "R3") ? "R3 perRead" : "R9 perRead", int'(pW), int'(expP));
        if (aW) ackCnt[g]++;
        // R5: VMA width
        if (vW) vRun++;
        else if (vRun > 0) begin
          if (rstN && rstP) chk(vRun == VmaLen, "R5 vmaOut width", vRun, VmaLen);
          vRun = 0;
        end
      end
      primed = 1'b1;
      prevE  = eW;
      asP    = addrStrobe;
      vpaP   = perDecode;
      rwP    = readNotWrite;
      rstP   = rstN;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clearAcks();
    clrAcks = 1'b1;
    tick(1);
    clrAcks = 1'b0;
  endtask

  function automatic int ackSum();
    int s = 0;
    for (int i = 0; i < NumPhases; i++) s += ackCnt[i];
    return s;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [NumPhases-1:0] toggled, lastE;
    for (int i = 0; i < NumPhases; i++) ackCnt[i] = 0;
    tick(3);
    @(negedge clk);
    // R3: reset state
    chk(vmaAll == '0, "R3 reset vmaOut", int'(vmaAll), 0);
    chk(ackAll == '0, "R3 reset ackOut", int'(ackAll), 0);
    tick(3);
    rstN = 1'b1;
    tick(12);

    // Vector table walk
    for (int v = 0; v < NumVecs; v++) begin
      clearAcks();
      tick(Vecs[v].gap);
      addrStrobe   = 1'b1;
      perDecode    = Vecs[v].vpa;
      readNotWrite = Vecs[v].rw;
      tick(Vecs[v].hold);
      addrStrobe = 1'b0;
      perDecode  = 1'b0;
      tick(22);
      if (Vecs[v].expAll == 2'd1)
        chk(ackSum() == NumPhases, "R4 R5 R8 every phase acknowledged", ackSum(), NumPhases);
      else if (Vecs[v].expAll == 2'd0)
        chk(ackSum() == 0, "R6 no acknowledge without decode", ackSum(), 0);
    end

    // R10: one acknowledge per held access
    clearAcks();
    addrStrobe   = 1'b1;
    perDecode    = 1'b1;
    readNotWrite = 1'b1;
    tick(40);
    addrStrobe = 1'b0;
    perDecode  = 1'b0;
    tick(4);
    for (int i = 0; i < NumPhases; i++)
      chk(ackCnt[i] == 1, "R10 single acknowledge", ackCnt[i], 1);
    tick(10);

    // R3: reset in the middle of a cycle; R2: strobe keeps running in reset
    addrStrobe = 1'b1;
    perDecode  = 1'b1;
    tick(14);
    rstN = 1'b0;
    @(negedge clk);
    chk(vmaAll == '0, "R3 mid-cycle reset vmaOut", int'(vmaAll), 0);
    toggled = '0;
    lastE   = eAll;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      toggled |= lastE ^ eAll;
      lastE    = eAll;
    end
    chk(toggled == '1, "R2 strobe toggles in reset", int'(toggled), int'({NumPhases{1'b1}}));
    addrStrobe = 1'b0;
    perDecode  = 1'b0;
    tick(1);
    rstN = 1'b1;
    tick(30);

    summary();
    $finish;
  end

endmodule